// File: doc/BRIEF.md
# Multi-Bank Command Responder with Shared Data-Path Token

This block is a synthesizable stand-in for the per-bank command engines that a memory crossbar talks to. Each bank takes one command at a time over a valid/ready handshake. It holds the command for a fixed processing delay and then competes with the other banks for a single data-path token. The token holder pulses a write-slot or read-slot strobe for exactly one cycle. Write data is sampled from the shared write bus a fixed latency after a write strobe. Read data is produced from an incrementing counter a fixed latency after a read strobe.

Each bank drives a lock flag, so an upstream arbiter can keep a bank reserved while that bank holds a command or is being offered one. Because the token lets only one strobe out at a time and read data is a running count, a test harness can check the end-to-end ordering of traffic through a crossbar from the event outputs alone. Row/column timing of a real memory is not modelled.

Top module: `bank_responder`

## Requirements
- R1: While reset is high, and in the first cycle after it, every ready, lock, strobe and event-valid output is 0 as long as no command valid is asserted.
- R2: A bank that is idle and sees its command valid in cycle c raises its ready in cycle c+1 for exactly one cycle. The write flag and address present in that ready cycle belong to the accepted command.
- R3: A bank's lock is 1 in every cycle where the bank holds an accepted command (from its ready cycle through its strobe cycle) or its command valid is 1. It is 0 in every other cycle.
- R4: With no other bank competing, a bank's strobe comes exactly PROC_DELAY+3 cycles after its ready cycle (cycle 9 after ready by default). Under contention it comes no earlier than that.
- R5: A command with write flag 1 produces a single one-cycle pulse on that bank's bit of wr_slot, and a command with write flag 0 produces a single one-cycle pulse on rd_slot. No bank pulses both in the same cycle.
- R6: At most one bank strobes in any cycle, and any two strobes are at least 3 cycles apart. When several banks wait for the token in the same cycle, the lowest bank index is served first.
- R7: A write strobe in cycle s samples wdata and wdata_be in cycle s+WR_LAT. In cycle s+WR_LAT+1, wev_valid is 1 and the sampled data and enables are shown together with the bank index and the held address.
- R8: A read strobe in cycle s gives rev_valid=1 in cycle s+RD_LAT, with the bank index and the held address.
- R9: After reset, the first read event carries rdata=0x10 (RD_BASE), and each later read event carries the previous value plus one.
- R10: After its strobe a bank is idle again. If its valid is low, its lock is 0 in the next cycle. If a new command is already valid in that cycle, ready follows in the cycle after (strobe cycle + 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NBANKS | Per-bank command valid |
| cmd_we | input | NBANKS | Per-bank write flag (1 = write, 0 = read) |
| cmd_addr | input | NBANKS*ADDR_W | Per-bank address, bank i in bits [i*ADDR_W +: ADDR_W] |
| cmd_ready | output | NBANKS | Per-bank one-cycle accept pulse |
| bank_lock | output | NBANKS | Per-bank reservation flag |
| wr_slot | output | NBANKS | Per-bank write-data strobe |
| rd_slot | output | NBANKS | Per-bank read strobe |
| wdata | input | DATA_W | Shared write data bus |
| wdata_be | input | DATA_W/8 | Shared byte enables |
| wev_valid | output | 1 | Write event captured |
| wev_bank | output | BANK_W | Bank of the write event |
| wev_addr | output | ADDR_W | Address of the write event |
| wev_data | output | DATA_W | Sampled write data |
| wev_be | output | DATA_W/8 | Sampled byte enables |
| rev_valid | output | 1 | Read event presented |
| rev_bank | output | BANK_W | Bank of the read event |
| rev_addr | output | ADDR_W | Address of the read event |
| rdata | output | DATA_W | Read data from the counter |

## Verification
The checker watches, on every cycle, that a single strobe is out at any time with the required spacing, that no bank pulses both strobe kinds, that ready lasts one cycle and is always covered by lock, and that read data steps by one from its base value. The exact strobe and event latencies, lowest-index service under contention, address and data capture, and the back-to-back acceptance after a strobe can only be shown by the bench's scenarios. The bench combines directed cases with randomised traffic on all banks and checks each cycle against its own event schedule.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_WAIT,
        ST_REQ,
        ST_HOLD,
        ST_STROBE
    } bank_st_e;

    // Width needed to index n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bcr_lat_pipe.sv
module bcr_lat_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/bcr_token_arbiter.sv
module bcr_token_arbiter #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] req,
    input  logic          release_i,
    output logic [NB-1:0] gnt,
    output logic          busy
);
    logic busy_q;
    logic found;

    // Lowest index wins, only while the token is free.
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        if (!busy_q) begin
            for (int i = 0; i < NB; i++) begin
                if (req[i] && !found) begin
                    gnt[i] = 1'b1;
                    found  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (|gnt)      busy_q <= 1'b1;
        else if (release_i) busy_q <= 1'b0;
    end

    assign busy = busy_q;
endmodule

// File: rtl/bcr_bank_engine.sv
module bcr_bank_engine
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PROC_DELAY = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              grant,
    output logic              cmd_ready,
    output logic              lock,
    output logic              req,
    output logic              wr_strobe,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] held_addr
);
    localparam int          CNT_W = idx_width(PROC_DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROC_DELAY - 1);

    bank_st_e          st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        st_q   <= ST_ACCEPT;
                        we_q   <= cmd_we;
                        addr_q <= cmd_addr;
                    end
                end
                ST_ACCEPT: begin
                    st_q  <= ST_WAIT;
                    cnt_q <= '0;
                end
                ST_WAIT: begin
                    if (cnt_q == CNT_LAST) st_q <= ST_REQ;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                ST_REQ:    if (grant) st_q <= ST_HOLD;
                ST_HOLD:   st_q <= ST_STROBE;
                ST_STROBE: st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (st_q == ST_ACCEPT);
    assign lock      = (st_q != ST_IDLE) || cmd_valid;
    assign req       = (st_q == ST_REQ);
    assign wr_strobe = (st_q == ST_STROBE) &&  we_q;
    assign rd_strobe = (st_q == ST_STROBE) && !we_q;
    assign held_addr = addr_q;
endmodule

// File: rtl/bank_responder.sv
module bank_responder
    import bcr_pkg::*;
#(
    parameter int NBANKS     = 4,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int PROC_DELAY = 6,
    parameter int WR_LAT     = 1,
    parameter int RD_LAT     = 5,
    parameter int RD_BASE    = 16,
    localparam int BANK_W    = idx_width(NBANKS),
    localparam int BE_W      = DATA_W / 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NBANKS-1:0]        cmd_valid,
    input  logic [NBANKS-1:0]        cmd_we,
    input  logic [NBANKS*ADDR_W-1:0] cmd_addr,
    output logic [NBANKS-1:0]        cmd_ready,
    output logic [NBANKS-1:0]        bank_lock,
    output logic [NBANKS-1:0]        wr_slot,
    output logic [NBANKS-1:0]        rd_slot,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [BE_W-1:0]          wdata_be,
    output logic                     wev_valid,
    output logic [BANK_W-1:0]        wev_bank,
    output logic [ADDR_W-1:0]        wev_addr,
    output logic [DATA_W-1:0]        wev_data,
    output logic [BE_W-1:0]          wev_be,
    output logic                     rev_valid,
    output logic [BANK_W-1:0]        rev_bank,
    output logic [ADDR_W-1:0]        rev_addr,
    output logic [DATA_W-1:0]        rdata
);
    localparam int TAG_W  = 1 + BANK_W + ADDR_W;
    localparam int RD_DLY = RD_LAT - 1;

    logic [NBANKS-1:0] req, gnt;
    logic [ADDR_W-1:0] held_addr [NBANKS];
    logic              tok_busy;

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        bcr_bank_engine #(
            .ADDR_W    (ADDR_W),
            .PROC_DELAY(PROC_DELAY)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .cmd_valid(cmd_valid[g]),
            .cmd_we   (cmd_we[g]),
            .cmd_addr (cmd_addr[g*ADDR_W +: ADDR_W]),
            .grant    (gnt[g]),
            .cmd_ready(cmd_ready[g]),
            .lock     (bank_lock[g]),
            .req      (req[g]),
            .wr_strobe(wr_slot[g]),
            .rd_strobe(rd_slot[g]),
            .held_addr(held_addr[g])
        );
    end

    bcr_token_arbiter #(.NB(NBANKS)) u_tok (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .release_i(|(wr_slot | rd_slot)),
        .gnt      (gnt),
        .busy     (tok_busy)
    );

    // Tag of the strobing bank: {valid, bank, addr}.
    logic [TAG_W-1:0] wtag, rtag, wtag_d, rtag_d;

    always_comb begin
        wtag = '0;
        rtag = '0;
        for (int i = 0; i < NBANKS; i++) begin
            if (wr_slot[i]) wtag = {1'b1, BANK_W'(i), held_addr[i]};
            if (rd_slot[i]) rtag = {1'b1, BANK_W'(i), held_addr[i]};
        end
    end

    bcr_lat_pipe #(.W(TAG_W), .DEPTH(WR_LAT)) u_wpipe (
        .clk(clk), .rst(rst), .d(wtag), .q(wtag_d)
    );

    bcr_lat_pipe #(.W(TAG_W), .DEPTH(RD_DLY)) u_rpipe (
        .clk(clk), .rst(rst), .d(rtag), .q(rtag_d)
    );

    // Write event: sample the shared bus when the delayed tag arrives.
    always_ff @(posedge clk) begin
        if (rst) begin
            wev_valid <= 1'b0;
            wev_bank  <= '0;
            wev_addr  <= '0;
            wev_data  <= '0;
            wev_be    <= '0;
        end else begin
            wev_valid <= wtag_d[TAG_W-1];
            if (wtag_d[TAG_W-1]) begin
                wev_bank <= wtag_d[ADDR_W +: BANK_W];
                wev_addr <= wtag_d[ADDR_W-1:0];
                wev_data <= wdata;
                wev_be   <= wdata_be;
            end
        end
    end

    // Read event: the output register absorbs the last latency cycle.
    logic [DATA_W-1:0] rd_ctr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rev_valid <= 1'b0;
            rev_bank  <= '0;
            rev_addr  <= '0;
            rdata     <= '0;
            rd_ctr_q  <= DATA_W'(RD_BASE);
        end else begin
            rev_valid <= rtag_d[TAG_W-1];
            if (rtag_d[TAG_W-1]) begin
                rev_bank <= rtag_d[ADDR_W +: BANK_W];
                rev_addr <= rtag_d[ADDR_W-1:0];
                rdata    <= rd_ctr_q;
                rd_ctr_q <= rd_ctr_q + 1'b1;
            end
        end
    end

    logic unused_busy;
    assign unused_busy = tok_busy;
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int NB      = 4,
    parameter int DW      = 16,
    parameter int RD_BASE = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [NB-1:0] cmd_ready,
    input logic [NB-1:0] bank_lock,
    input logic [NB-1:0] wr_slot,
    input logic [NB-1:0] rd_slot,
    input logic          rev_valid,
    input logic [DW-1:0] rdata
);
    logic [NB-1:0] stb;
    logic          seen_rd;
    logic [DW-1:0] last_rd;

    assign stb = wr_slot | rd_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rd <= 1'b0;
            last_rd <= '0;
        end else if (rev_valid) begin
            seen_rd <= 1'b1;
            last_rd <= rdata;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones(stb) <= 1);                                           // R6
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        (|stb) |-> (!$past(|stb) && !$past(|stb, 2)));                   // R6
    AST_NO_DUAL_KIND: assert property (@(posedge clk) disable iff (rst)
        (wr_slot & rd_slot) == '0);                                      // R5
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready & $past(cmd_ready)) == '0);                           // R2
    AST_READY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready & ~bank_lock) == '0);                                 // R3
    AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (stb & ~bank_lock) == '0);                                       // R3
    AST_RD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rev_valid && !seen_rd) |-> (rdata == DW'(RD_BASE)));            // R9
    AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
        (rev_valid && seen_rd) |-> (rdata == DW'(last_rd + 1'b1)));      // R9
endmodule

bind bank_responder bcr_checker #(
    .NB     (NBANKS),
    .DW     (DATA_W),
    .RD_BASE(RD_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_ready(cmd_ready),
    .bank_lock(bank_lock),
    .wr_slot  (wr_slot),
    .rd_slot  (rd_slot),
    .rev_valid(rev_valid),
    .rdata    (rdata)
);

// File: tb/tb_bank_responder.sv
module tb_bank_responder;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int BEW = DW / 8;
    localparam int BW  = 2;
    localparam int PD  = 6;
    localparam int WL  = 1;
    localparam int RL  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          v_b [NB];
    logic          w_b [NB];
    logic [AW-1:0] a_b [NB];
    logic [NB-1:0]    cmd_valid, cmd_we;
    logic [NB*AW-1:0] cmd_addr;
    logic [NB-1:0]    cmd_ready, bank_lock, wr_slot, rd_slot;
    logic [DW-1:0]    wdata;
    logic [BEW-1:0]   wdata_be;
    logic             wev_valid, rev_valid;
    logic [BW-1:0]    wev_bank, rev_bank;
    logic [AW-1:0]    wev_addr, rev_addr;
    logic [DW-1:0]    wev_data, rdata;
    logic [BEW-1:0]   wev_be;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cmd_valid[i]            = v_b[i];
            cmd_we[i]               = w_b[i];
            cmd_addr[i*AW +: AW]    = a_b[i];
        end
    end

    bank_responder #(
        .NBANKS(NB), .ADDR_W(AW), .DATA_W(DW), .PROC_DELAY(PD),
        .WR_LAT(WL), .RD_LAT(RL), .RD_BASE(16)
    ) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .bank_lock(bank_lock),
        .wr_slot(wr_slot), .rd_slot(rd_slot), .wdata(wdata), .wdata_be(wdata_be),
        .wev_valid(wev_valid), .wev_bank(wev_bank), .wev_addr(wev_addr),
        .wev_data(wev_data), .wev_be(wev_be), .rev_valid(rev_valid),
        .rev_bank(rev_bank), .rev_addr(rev_addr), .rdata(rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // Bench-side schedule of expected events, indexed by cycle mod 64.
    bit          ew_v [64];
    logic [BW-1:0] ew_b [64];
    logic [AW-1:0] ew_a [64];
    bit          er_v [64];
    logic [BW-1:0] er_b [64];
    logic [AW-1:0] er_a [64];

    bit      held    [NB];
    bit      pend_we [NB];
    logic [AW-1:0] pend_a [NB];
    int      rdy_cyc [NB];
    int      stb_cyc [NB];
    int      last_any = -100;
    int      next_rd  = 16;
    int      rev_cyc_last = -1;
    int      rev_dat_last = -1;
    logic [DW-1:0]  prev_wd;
    logic [BEW-1:0] prev_be;

    // Shared write bus changes every cycle.
    initial begin
        wdata = '0; wdata_be = '0;
        forever begin
            @(posedge clk); #1;
            wdata    = DW'($urandom);
            wdata_be = BEW'($urandom);
        end
    end

    // Cycle monitor, sampling away from the active edge.
    initial begin
        for (int i = 0; i < NB; i++) begin
            held[i] = 0; rdy_cyc[i] = -1; stb_cyc[i] = -1;
        end
        forever begin
            @(negedge clk);
            if (rst) begin
                for (int k = 0; k < 64; k++) begin ew_v[k] = 0; er_v[k] = 0; end
                next_rd = 16;
            end else begin
                for (int b = 0; b < NB; b++) begin
                    if (cmd_ready[b]) begin
                        chk(!held[b], "R2", "ready while command held", 1, 0);
                        held[b] = 1; pend_we[b] = w_b[b]; pend_a[b] = a_b[b];
                        rdy_cyc[b] = cyc;
                    end
                end
                for (int b = 0; b < NB; b++)
                    chk(bank_lock[b] == (held[b] | v_b[b]), "R3", "lock",
                        bank_lock[b], held[b] | v_b[b]);
                chk($countones(wr_slot | rd_slot) <= 1, "R6", "strobes per cycle",
                    $countones(wr_slot | rd_slot), 1);
                for (int b = 0; b < NB; b++) begin
                    if (wr_slot[b] || rd_slot[b]) begin
                        chk(held[b], "R5", "strobe without command", 0, 1);
                        chk(wr_slot[b] == pend_we[b], "R5", "strobe kind",
                            wr_slot[b], pend_we[b]);
                        chk(cyc >= rdy_cyc[b] + PD + 3, "R4", "strobe too early",
                            cyc - rdy_cyc[b], PD + 3);
                        chk(cyc - last_any >= 3, "R6", "strobe spacing",
                            cyc - last_any, 3);
                        last_any = cyc; stb_cyc[b] = cyc;
                        if (wr_slot[b]) begin
                            ew_v[(cyc+WL+1)%64] = 1;
                            ew_b[(cyc+WL+1)%64] = BW'(b);
                            ew_a[(cyc+WL+1)%64] = pend_a[b];
                        end else begin
                            er_v[(cyc+RL)%64] = 1;
                            er_b[(cyc+RL)%64] = BW'(b);
                            er_a[(cyc+RL)%64] = pend_a[b];
                        end
                        held[b] = 0;
                    end
                end
                if (ew_v[cyc%64] || wev_valid) begin
                    chk(wev_valid == ew_v[cyc%64], "R7", "wev_valid", wev_valid, ew_v[cyc%64]);
                    if (ew_v[cyc%64]) begin
                        chk(wev_bank == ew_b[cyc%64], "R7", "wev_bank", wev_bank, ew_b[cyc%64]);
                        chk(wev_addr == ew_a[cyc%64], "R7", "wev_addr", wev_addr, ew_a[cyc%64]);
                        chk(wev_data == prev_wd, "R7", "wev_data", wev_data, prev_wd);
                        chk(wev_be == prev_be, "R7", "wev_be", wev_be, prev_be);
                    end
                    ew_v[cyc%64] = 0;
                end
                if (er_v[cyc%64] || rev_valid) begin
                    chk(rev_valid == er_v[cyc%64], "R8", "rev_valid", rev_valid, er_v[cyc%64]);
                    if (er_v[cyc%64]) begin
                        chk(rev_bank == er_b[cyc%64], "R8", "rev_bank", rev_bank, er_b[cyc%64]);
                        chk(rev_addr == er_a[cyc%64], "R8", "rev_addr", rev_addr, er_a[cyc%64]);
                        chk(rdata == DW'(next_rd), "R9", "rdata", rdata, next_rd);
                        next_rd++;
                        rev_cyc_last = cyc; rev_dat_last = int'(rdata);
                    end
                    er_v[cyc%64] = 0;
                end
            end
            prev_wd = wdata; prev_be = wdata_be;
        end
    end

    // Present a command; keep valid high afterwards unless drop is set.
    task automatic issue(input int b, input bit we, input logic [AW-1:0] addr,
                         input bit drop, output int c0, output int rc);
        @(posedge clk); #1;
        v_b[b] = 1'b1; w_b[b] = we; a_b[b] = addr;
        c0 = cyc;
        forever begin
            @(negedge clk);
            if (cmd_ready[b]) break;
        end
        rc = cyc;
        if (drop) begin
            @(posedge clk); #1;
            v_b[b] = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0, rc, c1, rc1, s0;
        void'($urandom(32'd1234));
        for (int i = 0; i < NB; i++) begin v_b[i] = 0; w_b[i] = 0; a_b[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        chk({cmd_ready, bank_lock, wr_slot, rd_slot, wev_valid, rev_valid} == '0,
            "R1", "outputs in reset", {cmd_ready, bank_lock, wr_slot, rd_slot}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk({cmd_ready, bank_lock, wr_slot, rd_slot, wev_valid, rev_valid} == '0,
            "R1", "outputs after reset", {cmd_ready, bank_lock}, 0);

        // Directed: uncontended write on bank 1
        issue(1, 1'b1, 12'h123, 1'b1, c0, rc);
        chk(rc == c0 + 1, "R2", "ready cycle", rc - c0, 1);
        repeat (14) @(negedge clk);
        chk(stb_cyc[1] == rc + PD + 3, "R4", "write strobe cycle", stb_cyc[1] - rc, PD + 3);
        chk(bank_lock[1] == 1'b0, "R10", "lock after write done", bank_lock[1], 0);

        // Directed: uncontended read on bank 2, first read value
        issue(2, 1'b0, 12'h055, 1'b1, c0, rc);
        repeat (18) @(negedge clk);
        chk(stb_cyc[2] == rc + PD + 3, "R4", "read strobe cycle", stb_cyc[2] - rc, PD + 3);
        chk(rev_cyc_last == stb_cyc[2] + RL, "R8", "read latency",
            rev_cyc_last - stb_cyc[2], RL);
        chk(rev_dat_last == 16, "R9", "first read value", rev_dat_last, 16);

        // Directed: all banks together, lowest index first
        for (int b = 0; b < NB; b++) begin
            fork
                automatic int bb = b;
                begin
                    int x0, xr;
                    issue(bb, bb[0], AW'(12'h200 + bb), 1'b1, x0, xr);
                end
            join_none
        end
        wait fork;
        repeat (30) @(negedge clk);
        chk(stb_cyc[0] == rdy_cyc[0] + PD + 3, "R4", "bank0 first under contention",
            stb_cyc[0] - rdy_cyc[0], PD + 3);
        for (int b = 1; b < NB; b++)
            chk(stb_cyc[b] == stb_cyc[0] + 3 * b, "R6", "priority order",
                stb_cyc[b] - stb_cyc[0], 3 * b);

        // Directed: back-to-back command held valid on bank 0
        issue(0, 1'b0, 12'h0A0, 1'b0, c0, rc);
        s0 = rc + PD + 3;
        issue(0, 1'b1, 12'h0A1, 1'b1, c1, rc1);
        chk(stb_cyc[0] == s0, "R4", "first of pair strobe", stb_cyc[0] - rc, PD + 3);
        chk(rc1 == s0 + 2, "R10", "next ready after strobe", rc1 - s0, 2);
        repeat (16) @(negedge clk);

        // Random traffic on all banks
        for (int b = 0; b < NB; b++) begin
            fork
                automatic int bb = b;
                begin
                    int x0, xr;
                    for (int n = 0; n < 20; n++) begin
                        repeat ($urandom_range(0, 7)) @(posedge clk);
                        issue(bb, 1'($urandom), AW'($urandom), 1'($urandom_range(0, 3) != 0), x0, xr);
                    end
                    @(posedge clk); #1; v_b[bb] = 1'b0;
                end
            join_none
        end
        wait fork;
        repeat (60) @(negedge clk);
        for (int b = 0; b < NB; b++)
            chk(bank_lock[b] == 1'b0, "R10", "idle lock at end", bank_lock[b], 0);
        finish_run();
    end
endmodule